// File: doc/BRIEF.md
# TMDS Oversampling Bit Replicator

This block sits between a source of 10-bit TMDS symbols and a 20-bit transceiver word interface. It is used when the serial line rate is too low for the transceiver to run natively. The transceiver then runs at a higher rate, and every line bit is repeated k times so the far end sees the slower waveform. A 2-bit control picks k. Code 0 gives no repetition and is for TMDS rates of 1 Gb/s and above. Code 1 gives 3 copies for rates from 350 up to 500 Mb/s. Code 2 gives 4 copies for rates from 300 up to 350 Mb/s. Code 3 gives 5 copies for rates from 250 up to 300 Mb/s, and also from 500 Mb/s up to 1 Gb/s.

Symbols arrive as pairs in one 20-bit beat. The symbol in bits [9:0] goes out first, and within it bit 0 goes out first. The expanded bits collect in a small buffer. The buffer gives out exactly one 20-bit word per clock, with the word's bit 0 earliest on the line. A pair expands to 20·k bits, which is k output words. A ready/valid handshake therefore throttles the source to one pair every k clocks in steady streaming.

A change of the control input discards everything buffered, so packing restarts on a symbol boundary. If the buffer runs dry after it has delivered data, the block sends an all-zero word and latches an underflow flag.

Top module: `tmds_os_packer`

## Requirements
- R1: Control code 0 selects k=1, code 1 selects k=3, code 2 selects k=4 and code 3 selects k=5 copies of every input bit.
- R2: Input bit j of a beat (0..19; bits [9:0] are the first symbol) appears at expanded stream positions j·k through j·k+k-1. All copies of a bit are adjacent, and lower bits come first.
- R3: One 20-bit word leaves per clock, and output bit 0 is the earliest bit of the word. With data available, consecutive words carry consecutive 20-bit slices of the expanded stream.
- R4: `in_ready` is high only when the buffer, after this clock's outgoing word, has room for all 20·k bits of a new beat. The buffer never holds more than its capacity.
- R5: With code 0 and no pending change, `in_ready` is high every clock. A beat accepted at one clock edge appears unchanged on `out_word` after the next edge.
- R6: When `os_sel` differs from the mode in use, `in_ready` is low for that clock. The word after that edge is all zeros, and the buffer is emptied, so no earlier data is sent afterwards.
- R7: When the buffer is empty, the next word is all zeros. If at least one data word has been sent since the last reset or mode change, `underflow` goes high and stays high until reset.
- R8: After reset, `out_word` is zero, `underflow` is low and, with code 0 applied, `in_ready` is high.
- R9: With `in_valid` held high, words leave without gaps. In steady state one beat is accepted every k clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| os_sel | input | 2 | Oversampling code (0: none, 1: 3x, 2: 4x, 3: 5x) |
| in_valid | input | 1 | Symbol pair offered |
| in_pair | input | 20 | Two symbols; bits [9:0] go out first |
| in_ready | output | 1 | Pair is taken at this edge when high together with in_valid |
| out_word | output | 20 | Transceiver word, bit 0 earliest |
| underflow | output | 1 | Sticky flag: an empty buffer forced a zero word after data had flowed |

## Verification
The bench streams distinct pairs in every mode and rebuilds the expected words from its own expansion. A wrong code-to-factor map, swapped copy order or off-by-one in the packing offset therefore shows up as mismatched words. It measures the gap between the last two accepted beats: a ready rule that admits too early would overrun the buffer, and one that is too strict would open gaps in the output stream. It switches modes with data still buffered. Stale bits that survive the flush would show up as unexpected words ahead of the new stream. Finally it starves the buffer and then resumes, to catch a missing zero word, a flag that clears itself, or a flag that fires at start-up.

// File: rtl/tmds_os_packer.sv
module tmds_os_packer #(
  parameter int SYM_W     = 10,
  parameter int BUF_WORDS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           os_sel,
  input  logic                 in_valid,
  input  logic [2*SYM_W-1:0]   in_pair,
  output logic                 in_ready,
  output logic [2*SYM_W-1:0]   out_word,
  output logic                 underflow
);
  localparam int WORD_W = 2 * SYM_W;
  localparam int MAX_K  = 5;
  localparam int EXP_W  = MAX_K * WORD_W;
  localparam int BUF_W  = BUF_WORDS * WORD_W;
  localparam int CW     = $clog2(BUF_WORDS + 1);

  logic [1:0]        os_q;
  logic [BUF_W-1:0]  bits_q;
  logic [CW-1:0]     cnt;
  logic              primed;
  logic [2:0]        k;
  logic [EXP_W-1:0]  exp_v [4];
  logic [CW-1:0]     cnt_d;
  logic [CW:0]       need;
  logic              swap, take;
  logic [BUF_W-1:0]  drained, bits_n;

  always_comb begin
    case (os_q)
      2'd0:    k = 3'd1;
      2'd1:    k = 3'd3;
      2'd2:    k = 3'd4;
      default: k = 3'd5;
    endcase
  end

  for (genvar g = 0; g < 4; g++) begin : g_mode
    localparam int KK = (g == 0) ? 1 : g + 2;
    for (genvar i = 0; i < EXP_W; i++) begin : g_bit
      if (i < WORD_W * KK) begin : g_on
        assign exp_v[g][i] = in_pair[i / KK];
      end else begin : g_off
        assign exp_v[g][i] = 1'b0;
      end
    end
  end

  assign swap     = (os_sel != os_q);
  assign cnt_d    = (cnt != '0) ? cnt - CW'(1) : cnt;
  assign need     = {1'b0, cnt_d} + (CW+1)'(k);
  assign in_ready = !swap && (need <= (CW+1)'(BUF_WORDS));
  assign take     = in_valid && in_ready;
  assign drained  = (cnt != '0) ? (bits_q >> WORD_W) : bits_q;
  assign bits_n   = take ? (drained | (BUF_W'(exp_v[os_q]) << (cnt_d * WORD_W))) : drained;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      os_q      <= 2'd0;
      bits_q    <= '0;
      cnt       <= '0;
      primed    <= 1'b0;
      out_word  <= '0;
      underflow <= 1'b0;
    end else if (swap) begin
      os_q     <= os_sel;
      bits_q   <= '0;
      cnt      <= '0;
      primed   <= 1'b0;
      out_word <= '0;
    end else begin
      bits_q   <= bits_n;
      cnt      <= take ? CW'(need) : cnt_d;
      out_word <= (cnt != '0) ? bits_q[WORD_W-1:0] : '0;
      if (cnt != '0) primed <= 1'b1;
      else if (primed) underflow <= 1'b1;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BUF_WORDS));
  assert_ready_low_on_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swap |-> !in_ready);
  assert_flush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    swap |=> (out_word == '0 && cnt == '0));
  assert_zero_when_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0) |=> (out_word == '0));
  assert_sticky_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> underflow);
  assert_bypass_ready_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (os_sel == 2'd0 && os_q == 2'd0) |-> in_ready);
endmodule

// File: tb/tmds_os_packer_tb.sv
module tmds_os_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  os_sel;
  logic        in_valid;
  logic [19:0] in_pair;
  logic        in_ready;
  logic [19:0] out_word;
  logic        underflow;
  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  tmds_os_packer dut_i (
    .clk(clk), .rst_n(rst_n), .os_sel(os_sel), .in_valid(in_valid),
    .in_pair(in_pair), .in_ready(in_ready), .out_word(out_word), .underflow(underflow)
  );

  function automatic int k_of(logic [1:0] s);
    return (s == 2'd0) ? 1 : s + 2;
  endfunction

  function automatic logic [99:0] expand(logic [19:0] p, int k);
    logic [99:0] e = '0;
    for (int j = 0; j < 20; j++)
      for (int r = 0; r < k; r++) e[j*k + r] = p[j];
    return e;
  endfunction

  function automatic logic [19:0] pair_of(int base, int i);
    return ((20'(base) * 20'h1357) + (20'(i) * 20'h2E9B)) | 20'h1;
  endfunction

  task automatic check(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(logic [1:0] s);
    rst_n = 1'b0; os_sel = s; in_valid = 1'b0; in_pair = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic run_stream(logic [1:0] sel, int n, int base, bit check_uf, string req);
    logic [19:0] rec [256];
    logic        ruf [256];
    int acc [16];
    int idx = 0, nacc = 0, start = -1, k = k_of(sel), lim = n*5 + 20, bad = 0;
    logic [19:0] badv = '0, bade = '0;
    bit hs;
    os_sel = sel;
    for (int c = 0; c < lim; c++) begin
      in_valid = (idx < n);
      in_pair  = pair_of(base, idx);
      #1;
      hs = in_valid && in_ready;
      @(negedge clk);
      rec[c] = out_word; ruf[c] = underflow;
      if (hs) begin acc[nacc] = c; nacc++; idx++; end
    end
    in_valid = 1'b0;
    for (int c = 0; c < lim; c++) if (start < 0 && rec[c] != '0) start = c;
    for (int i = 0; i < n*k; i++) begin
      logic [19:0] e;
      e = expand(pair_of(base, i / k), k)[(i % k)*20 +: 20];
      if (start < 0 || start + i >= lim || rec[start + i] != e) begin
        if (bad == 0) begin badv = (start < 0 || start + i >= lim) ? 20'h0 : rec[start + i]; bade = e; end
        bad++;
      end
    end
    check(bad == 0, req, "expanded word stream", 32'(badv), 32'(bade));
    if (check_uf)
      check(start >= 0 && ruf[start + n*k - 1] == 1'b0, "R9", "no underflow while streaming",
            32'(start >= 0 ? ruf[start + n*k - 1] : 1'b1), 0);
    if (n >= 3)
      check(acc[n-1] - acc[n-2] == k, "R9", "steady accept interval", 32'(acc[n-1] - acc[n-2]), 32'(k));
    if (sel == 2'd0)
      check(acc[n-1] - acc[0] == n - 1, "R5", "bypass ready every clock", 32'(acc[n-1] - acc[0]), 32'(n - 1));
  endtask

  task automatic test_reset();
    do_reset(2'd0);
    #1;
    check(out_word == '0, "R8", "reset out_word", 32'(out_word), 0);
    check(underflow == 1'b0, "R8", "reset underflow", 32'(underflow), 0);
    check(in_ready == 1'b1, "R8", "reset in_ready", 32'(in_ready), 1);
    @(negedge clk);
  endtask

  task automatic test_bypass_latency();
    do_reset(2'd0);
    in_valid = 1'b1; in_pair = 20'hA5C3F;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check(out_word == 20'hA5C3F, "R5", "one-edge-later pass-through", 32'(out_word), 32'h0A5C3F);
  endtask

  task automatic test_modes();
    do_reset(2'd0); run_stream(2'd0, 6, 1, 1, "R3");
    do_reset(2'd0); run_stream(2'd1, 5, 2, 1, "R1");
    do_reset(2'd0); run_stream(2'd2, 4, 3, 1, "R2");
    do_reset(2'd0); run_stream(2'd3, 4, 4, 1, "R1");
  endtask

  task automatic test_mode_change();
    int got = 0;
    do_reset(2'd1);
    in_valid = 1'b1;
    while (got < 2) begin
      in_pair = pair_of(9, got);
      #1;
      if (in_ready) got++;
      @(negedge clk);
    end
    in_valid = 1'b0;
    os_sel = 2'd2;
    #1;
    check(in_ready == 1'b0, "R6", "ready low on control change", 32'(in_ready), 0);
    @(negedge clk);
    check(out_word == '0, "R6", "zero word after flush", 32'(out_word), 0);
    run_stream(2'd2, 3, 11, 1, "R6");
  endtask

  task automatic test_underflow();
    do_reset(2'd0);
    run_stream(2'd3, 1, 21, 0, "R7");
    check(out_word == '0, "R7", "zero word on underrun", 32'(out_word), 0);
    check(underflow == 1'b1, "R7", "flag set on underrun", 32'(underflow), 1);
    run_stream(2'd3, 2, 22, 0, "R7");
    check(underflow == 1'b1, "R7", "flag remains set", 32'(underflow), 1);
  endtask

  task automatic test_no_false_flag();
    do_reset(2'd3);
    repeat (6) @(negedge clk);
    check(underflow == 1'b0, "R7", "no flag before any data", 32'(underflow), 0);
  endtask

  initial begin
    test_reset();
    test_bypass_latency();
    test_modes();
    test_mode_change();
    test_underflow();
    test_no_false_flag();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule